// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block is a management-interface master that sends exactly one Clause 45 management frame for each command issued by software. Software talks to it through a small register port with three registers. The frame register (selector 0) holds a packed 32-bit frame word. The control register (selector 1) holds a launch bit in bit 3. The status register (selector 2) reports a busy flag in bit 0. Software fills the frame word and then toggles the launch bit. It polls busy until the flag clears. For a read frame it then collects the PHY's reply from the low half of the frame register.

The frame word packs its fields from the top down:

| Bits | Field | Value software programs |
|------|-------|-------------------------|
| 31:30 | start code | 00 |
| 29:28 | operation | 00 address, 01 write, 11 read |
| 27:23 | port address | — |
| 22:18 | device address | — |
| 17:16 | turnaround | 10 |
| 15:0 | address or data | — |

Each frame starts with a 32-bit run of ones. The 32 bits of the frame word then follow, most significant bit first. The management clock is produced from the system clock by a divider that is set at build time. A complete register access takes two frames, an address frame followed by a read or write frame. Chaining the two is left to software.

Top module: `mdio_c45_master`

## Requirements
- R1: After reset, status bit 0 reads 0, `mdc` is low, `mdio_oe` is low, and the frame register reads 0.
- R2: A host write to the control register (selector 1) launches a frame only when it changes bit 3 from 0 to 1. Status bit 0 reads 1 from the next clock onward.
- R3: While busy, the master sends 64 bits on `mdio_o`: first 32 ones, then frame-register bits 31 down to 0. Each bit is sampled at a rising edge of `mdc`.
- R4: `mdc` has a period of 2*HALF_DIV system clocks. It gives exactly 64 rising edges per frame and stays low when idle.
- R5: `mdio_o` changes only right after a falling edge of `mdc`. It holds its value for the whole high phase of `mdc`.
- R6: On a read frame (operation bits 29:28 = 11), `mdio_oe` is low for bit positions 46 to 63, which cover turnaround and data. It is high for every other bit position. On any other frame, `mdio_oe` is high for all 64 bits.
- R7: On a read frame, `mdio_i` is sampled at the rising `mdc` edges of bit positions 48 to 63. The first bit sampled is the data MSB. The 16-bit result replaces frame-register bits 15:0 when the frame ends, and bits 31:16 are kept.
- R8: Status bit 0 returns to 0 after the 64th `mdc` cycle of a frame.
- R9: A launch edge on control bit 3 that arrives while busy is ignored. The frame in flight is unchanged, and no further frame follows it.
- R10: A host write to the frame register during a frame updates the register but does not change the bits being sent.
- R11: Writing control bit 3 as 1 when it is already 1 does not launch a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host register write strobe |
| wr_sel | input | 2 | Write register select: 0 frame, 1 control, 2 status |
| wr_data | input | 32 | Host write data |
| rd_sel | input | 2 | Read register select, same encoding as `wr_sel` |
| rd_data | output | 32 | Selected register contents (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data driven toward the PHY |
| mdio_oe | output | 1 | High while the master drives the data line |
| mdio_i | input | 1 | Serial data received from the line |

## Verification
Several kinds of internal fault show up at the ports, each within a known time:
- A bit counter or shift register that drifts shows up as a wrong bit on `mdio_o` at the very next `mdc` rising edge.
- An off-by-one in the release window shows up as `mdio_oe` falling one MDC period too early or too late.
- A stuck busy flag shows up as a 65th `mdc` edge, or as status bit 0 still set two clocks after the last falling edge.
- A receive path that shifts wrongly leaves a byte- or bit-swapped value in frame bits 15:0, visible as soon as the frame ends.
- Stale launch detection shows up as a second frame starting, within HALF_DIV clocks, after an ignored or repeated launch write.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [1:0] {
    SEL_FRAME = 2'd0,
    SEL_CTRL  = 2'd1,
    SEL_STAT  = 2'd2
  } reg_sel_e;

  localparam int WORD_W     = 32;
  localparam int DATA_W     = 16;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = PRE_BITS + WORD_W;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam int TA_POS     = PRE_BITS + 14;
  localparam int DATA_POS   = PRE_BITS + 16;
  localparam int LAUNCH_BIT = 3;
  localparam logic [1:0] OP_READ = 2'b11;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          tick;

  assign tick      = en && (cnt_q == LAST);
  assign rise_tick = tick && !mdc_q;
  assign fall_tick = tick && mdc_q;
  assign mdc       = mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!en) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      mdc_d = !mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  // R4: the clock only moves on a divider tick
  p_mdc_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(mdc_q));
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] frame_in,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic              is_read,
  output logic [DATA_W-1:0] rx_data
);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] PRE_END  = CNT_W'(PRE_BITS);
  localparam logic [CNT_W-1:0] TA_AT    = CNT_W'(TA_POS);
  localparam logic [CNT_W-1:0] DATA_AT  = CNT_W'(DATA_POS);

  logic                  busy_q, busy_d;
  logic [FRAME_BITS-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]      pos_q, pos_d;
  logic                  rd_q, rd_d;
  logic [DATA_W-1:0]     rx_q, rx_d;

  always_comb begin
    busy_d = busy_q;
    sr_d   = sr_q;
    pos_d  = pos_q;
    rd_d   = rd_q;
    rx_d   = rx_q;
    done   = 1'b0;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      sr_d   = {{PRE_BITS{1'b1}}, frame_in};
      pos_d  = '0;
      rd_d   = (frame_in[29:28] == OP_READ);
      rx_d   = '0;
    end else if (busy_q) begin
      if (rise_tick && rd_q && (pos_q >= DATA_AT))
        rx_d = {rx_q[DATA_W-2:0], mdio_i};
      if (fall_tick) begin
        if (pos_q == LAST_POS) begin
          busy_d = 1'b0;
          done   = 1'b1;
        end else begin
          sr_d  = {sr_q[FRAME_BITS-2:0], 1'b0};
          pos_d = pos_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sr_q   <= '0;
      pos_q  <= '0;
      rd_q   <= 1'b0;
      rx_q   <= '0;
    end else begin
      busy_q <= busy_d;
      sr_q   <= sr_d;
      pos_q  <= pos_d;
      rd_q   <= rd_d;
      rx_q   <= rx_d;
    end
  end

  assign busy    = busy_q;
  assign is_read = rd_q;
  assign rx_data = rx_q;
  assign mdio_o  = busy_q ? sr_q[FRAME_BITS-1] : 1'b1;
  assign mdio_oe = busy_q && !(rd_q && (pos_q >= TA_AT));

  // R3: preamble positions are all ones
  p_preamble_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (pos_q < PRE_END)) |-> mdio_o);
  // R5: the data line only moves on an MDC falling edge
  p_hold_between_falls_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !fall_tick) |=> $stable(mdio_o));
  // R6: non-read frames drive every bit
  p_drive_nonread_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !rd_q) |-> mdio_oe);
  // R9: a launch while busy leaves the shift state alone
  p_ignore_launch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && !fall_tick) |=> $stable(sr_q));
endmodule

// File: rtl/mdio_c45_master.sv
module mdio_c45_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_sel,
  output logic [31:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [WORD_W-1:0] frame_q, frame_d;
  logic [WORD_W-1:0] ctrl_q, ctrl_d;
  logic              wr_frame, wr_ctrl, launch;
  logic              busy, done, is_read;
  logic              rise_tick, fall_tick;
  logic [DATA_W-1:0] rx_data;

  assign wr_frame = wr_en && (wr_sel == SEL_FRAME);
  assign wr_ctrl  = wr_en && (wr_sel == SEL_CTRL);
  assign launch   = wr_ctrl && wr_data[LAUNCH_BIT] && !ctrl_q[LAUNCH_BIT] && !busy;

  always_comb begin
    frame_d = frame_q;
    ctrl_d  = ctrl_q;
    if (wr_frame) frame_d = wr_data;
    if (done && is_read) frame_d[DATA_W-1:0] = rx_data;
    if (wr_ctrl) ctrl_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      ctrl_q  <= '0;
    end else begin
      frame_q <= frame_d;
      ctrl_q  <= ctrl_d;
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_FRAME: rd_data = frame_q;
      SEL_CTRL:  rd_data = ctrl_q;
      SEL_STAT:  rd_data = {{(WORD_W-1){1'b0}}, busy};
      default:   rd_data = '0;
    endcase
  end

  mdio_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (busy),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (launch),
    .frame_in  (frame_q),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_i    (mdio_i),
    .busy      (busy),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .done      (done),
    .is_read   (is_read),
    .rx_data   (rx_data)
  );

  // R4: the management clock rests low while idle
  p_mdc_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  // R10: the frame word changes only by host write or read completion
  p_frame_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_frame && !(done && is_read)) |=> $stable(frame_q));
  // R2: a launch always raises busy on the next clock
  p_launch_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);
endmodule

// File: tb/sim_mdio_c45_master.sv
module sim_mdio_c45_master;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_c45_master #(.HALF_DIV(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  function automatic logic exp_bit(input logic [31:0] f, input int i);
    return (i < 32) ? 1'b1 : f[63-i];
  endfunction

  function automatic logic exp_oe(input logic [31:0] f, input int i);
    return !((f[29:28] == 2'b11) && (i >= 46));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic host_rd(input logic [1:0] s, output logic [31:0] d);
    rd_sel = s;
    #1;
    d = rd_data;
  endtask

  task automatic run_frame(input logic [31:0] f, input logic [15:0] rdat, input bit interfere);
    logic [31:0] v;
    int bit_err, oe_err, hold_err, rises;
    time t0, t1;
    bit rd;
    rd = (f[29:28] == 2'b11);
    bit_err = 0; oe_err = 0; hold_err = 0; rises = 0; t0 = 0; t1 = 0;
    host_wr(2'd0, f);
    host_wr(2'd1, 32'h5);
    host_wr(2'd1, 32'hD);
    host_rd(2'd2, v);
    chk(v[0] == 1'b1, "R2 busy after launch edge", 64'(v[0]), 64'd1);
    fork
      begin
        for (int i = 0; i < 64; i++) begin
          logic a, b, o;
          @(posedge mdc);
          #1;
          rises++;
          if (i == 0) t0 = $time;
          if (i == 1) t1 = $time;
          a = mdio_o; o = mdio_oe;
          if (o != exp_oe(f, i)) oe_err++;
          if (exp_oe(f, i) && (a != exp_bit(f, i))) bit_err++;
          #(HALF*CLK_PERIOD - 2);
          b = mdio_o;
          if (o && (a != b)) hold_err++;
          @(negedge mdc);
          #1;
          if (rd && (i + 1 >= 48) && (i + 1 <= 63)) mdio_i = rdat[62-i];
          else mdio_i = 1'b1;
        end
      end
      begin
        host_wr(2'd1, 32'h5);
        if (interfere) begin
          repeat (20) @(negedge clk);
          host_wr(2'd0, ~f);
          host_wr(2'd1, 32'hD);
          host_wr(2'd1, 32'h5);
        end
      end
    join
    mdio_i = 1'b1;
    chk(bit_err == 0, interfere ? "R10 R3 bits unchanged by mid-frame writes" : "R3 serial bits",
        64'(bit_err), 64'd0);
    chk(oe_err == 0, "R6 output enable per bit", 64'(oe_err), 64'd0);
    chk(hold_err == 0, "R5 data held through MDC high", 64'(hold_err), 64'd0);
    chk((t1 - t0) == 2*HALF*CLK_PERIOD, "R4 MDC period", 64'(t1 - t0), 64'(2*HALF*CLK_PERIOD));
    repeat (2) @(negedge clk);
    host_rd(2'd2, v);
    chk(v[0] == 1'b0, "R8 busy clear after frame", 64'(v[0]), 64'd0);
    if (interfere) begin
      repeat (4*HALF) @(negedge clk);
      host_rd(2'd2, v);
      chk((v[0] == 1'b0) && !mdc, "R9 no relaunch from ignored edge", 64'({v[0], mdc}), 64'd0);
    end
    host_rd(2'd0, v);
    if (rd) begin
      logic [31:0] e;
      e = interfere ? {~f[31:16], rdat} : {f[31:16], rdat};
      chk(v == e, "R7 read data in frame low half", 64'(v), 64'(e));
    end else begin
      logic [31:0] e;
      e = interfere ? ~f : f;
      chk(v == e, "R10 frame register holds host value", 64'(v), 64'(e));
    end
  endtask

  function automatic logic [31:0] mk_frame(input logic [1:0] op, input logic [4:0] pa,
                                           input logic [4:0] da, input logic [15:0] ad);
    return {2'b00, op, pa, da, 2'b10, ad};
  endfunction

  initial begin
    logic [31:0] v;
    int guard;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    host_rd(2'd2, v);
    chk(v == 32'd0, "R1 status after reset", 64'(v), 64'd0);
    chk(!mdc && !mdio_oe, "R1 lines after reset", 64'({mdc, mdio_oe}), 64'd0);
    host_rd(2'd0, v);
    chk(v == 32'd0, "R1 frame register after reset", 64'(v), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_frame(mk_frame(2'b00, 5'd3, 5'd5, 16'hA55A), 16'h0, 1'b0);
    run_frame(mk_frame(2'b11, 5'd31, 5'd5, 16'h0000), 16'h8001, 1'b0);
    run_frame(mk_frame(2'b01, 5'd0, 5'd1, 16'hFFFF), 16'h0, 1'b0);
    run_frame(mk_frame(2'b11, 5'd7, 5'd30, 16'h0000), 16'hC3E1, 1'b1);
    run_frame(mk_frame(2'b01, 5'd9, 5'd2, 16'h1234), 16'h0, 1'b1);

    for (int k = 0; k < 6; k++) begin
      logic [1:0] op;
      int p;
      p = int'($urandom % 3);
      op = (p == 0) ? 2'b00 : (p == 1) ? 2'b01 : 2'b11;
      run_frame(mk_frame(op, 5'($urandom), 5'($urandom), 16'($urandom)), 16'($urandom), 1'b0);
    end

    // R11: repeated 1 on the launch bit does not start a frame
    host_wr(2'd1, 32'hD);
    guard = 0;
    do begin
      @(negedge clk);
      host_rd(2'd2, v);
      guard++;
    end while (v[0] && guard < 2000);
    chk(v[0] == 1'b0, "R8 directed frame completes", 64'(v[0]), 64'd0);
    host_wr(2'd1, 32'hD);
    repeat (2*HALF) @(negedge clk);
    host_rd(2'd2, v);
    chk((v[0] == 1'b0) && !mdc, "R11 no launch without 0 to 1 edge", 64'({v[0], mdc}), 64'd0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule